// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a two-wire (I2C) bus target that fronts a 256-word by 8-bit storage array, held here as a register file. SCL and SDA are sampled with the system clock. SDA is driven open-drain: while `sda_oe` is high, the pad pulls the line low. A 7-bit device address decides whether the block takes part in a transfer. Its upper nibble is the constant 1010 and its lower three bits come from strap pins, so eight of these blocks can share one bus.

A write transfer carries the device address with the direction bit 0, then one word-address byte, then data bytes. The data bytes collect in an eight-entry page buffer. The buffer is written to the array in one step at STOP. An erase/write timer then starts. While it runs, the block refuses its own address. The timer counts either system clocks or pulses on an external tick input.

A read transfer with the direction bit 1 returns bytes starting at the current word-address counter. The counter advances after every byte, so a read continues from where the last transfer ended. A random read sets the counter with a write of the word address and reaches the read through a repeated START.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The block acknowledges a device address byte only when its upper seven bits equal 1010 followed by `strap[2:0]`. For any other address it leaves SDA released. Bit 0 of the address byte is the direction: 0 selects write and 1 selects read.
- R2: Every byte is shifted most significant bit first. For each byte the block receives and accepts, it holds SDA low for the whole ninth clock.
- R3: A single data byte written after a word address is stored at that address once STOP arrives. It reads back unchanged.
- R4: During a write, only the low three bits of the word address advance, so data stays inside the 8-byte page. A ninth byte overwrites the first slot it used. Words outside the page are left unchanged.
- R5: After a STOP that ends a write with at least one data byte, the block refuses its own address for WR_CYCLES system clocks. After that it acknowledges again.
- R6: With `tick_sel` high, the erase/write timer advances only on cycles where `ext_tick` is high. Without ticks the block stays busy indefinitely.
- R7: A read sent straight after START returns the word at the current counter. After a page write, the counter is the wrapped in-page position following the last byte written.
- R8: A write of a word address, then a repeated START, then a read address returns data starting at that word address.
- R9: A sequential read keeps returning successive words while the controller acknowledges. The full 8-bit counter wraps from 255 to 0.
- R10: When the controller does not acknowledge a read byte and then sends STOP, the block releases SDA and stays released.
- R11: After reset, SDA is released, the counter is 0 and the block is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap | input | 3 | Low three device address bits |
| tick_sel | input | 1 | 1 = time the erase/write cycle with `ext_tick`, 0 = with system clocks |
| ext_tick | input | 1 | External timing pulse, one system clock wide |
| sda_oe | output | 1 | 1 = pull SDA low |

## Verification
Two functions can meet in the same cycle: the erase/write timer is still counting down when the acknowledge decision for a fresh device address is made. The bench provokes this by sending the block's own address immediately after the STOP that starts a write cycle. The address completes well inside the timer window, so a missing acknowledge is expected. A second attempt after the window must be acknowledged. The same race is repeated in external-tick mode: no ticks are supplied while the bench waits for a long stretch, and then exactly enough ticks are delivered.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int          WR_CYCLES = 400,
  parameter int          PAGE_BITS = 3,
  parameter logic [3:0]  DEV_CODE  = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  input  logic       tick_sel,
  input  logic       ext_tick,
  output logic       sda_oe
);
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PAGE_BITS;
  localparam int CW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {IDLE, DEV, WA, WD, RD} st_t;

  logic [2:0] scl_q, sda_q;
  logic       scl, sda, start, stop, rise, fall;
  st_t        st;
  logic [3:0] bc;
  logic [7:0] sr, obyte;
  logic       rw, acked, mack;
  logic [AW-1:0] addr;
  logic [AW-PAGE_BITS-1:0] pbase;
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] mask;
  logic [7:0] mem [DEPTH];
  logic [CW-1:0] tmr;
  logic       busy;

  assign scl   = scl_q[1];
  assign sda   = sda_q[1];
  assign rise  = scl & ~scl_q[2];
  assign fall  = ~scl & scl_q[2];
  assign start = scl & scl_q[2] & sda_q[2] & ~sda;
  assign stop  = scl & scl_q[2] & ~sda_q[2] & sda;
  assign busy  = |tmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1; sda_q <= '1;
      st <= IDLE; bc <= '0; sr <= '0; obyte <= '0;
      rw <= 1'b0; acked <= 1'b0; mack <= 1'b0;
      addr <= '0; pbase <= '0; mask <= '0; tmr <= '0; sda_oe <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (busy && (!tick_sel || ext_tick)) tmr <= tmr - 1'b1;
      if (stop) begin
        st <= IDLE; bc <= '0; sda_oe <= 1'b0;
        if (|mask) begin
          for (int i = 0; i < PAGE; i++)
            if (mask[i]) mem[{pbase, PAGE_BITS'(i)}] <= pbuf[i];
          mask <= '0;
          tmr  <= CW'(WR_CYCLES);
        end
      end else if (start) begin
        st <= DEV; bc <= '0; sda_oe <= 1'b0;
      end else if (st != IDLE) begin
        if (rise) begin
          if (bc < 4'd8) sr <= {sr[6:0], sda};
          else mack <= ~sda;
          bc <= bc + 4'd1;
        end
        if (fall) begin
          if (bc == 4'd8) begin
            case (st)
              DEV: begin
                acked  <= (sr[7:1] == {DEV_CODE, strap}) && !busy;
                sda_oe <= (sr[7:1] == {DEV_CODE, strap}) && !busy;
                rw     <= sr[0];
              end
              WA: begin
                addr <= sr; pbase <= sr[7:PAGE_BITS]; mask <= '0; sda_oe <= 1'b1;
              end
              WD: begin
                pbuf[addr[PAGE_BITS-1:0]] <= sr;
                mask[addr[PAGE_BITS-1:0]] <= 1'b1;
                addr[PAGE_BITS-1:0] <= addr[PAGE_BITS-1:0] + 1'b1;
                sda_oe <= 1'b1;
              end
              RD: begin
                sda_oe <= 1'b0; addr <= addr + 1'b1;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bc == 4'd9) begin
            bc <= '0; sda_oe <= 1'b0;
            case (st)
              DEV: if (!acked) st <= IDLE;
                   else if (rw) begin
                     st <= RD; obyte <= mem[addr]; sda_oe <= ~mem[addr][7];
                   end else st <= WA;
              WA: st <= WD;
              RD: if (mack) begin
                    obyte <= mem[addr]; sda_oe <= ~mem[addr][7];
                  end else st <= IDLE;
              default: ;
            endcase
          end else if (st == RD && bc != 4'd0) begin
            sda_oe <= ~obyte[6];
            obyte  <= {obyte[6:0], 1'b0};
          end
        end
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) |-> !sda_oe); // R10
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DEV && busy) |-> !sda_oe); // R5
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start) && !$past(stop)) |-> !scl); // R2
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop)); // R5
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick_sel && !ext_tick && !stop) |=> $stable(tmr)); // R6
endmodule

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, tick_sel = 1'b0, ext_tick = 1'b0;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;
  int   errs = 0, checks = 0;
  logic [7:0] dbuf [16];
  logic [7:0] rbuf [16];
  localparam logic [7:0] AW_W = 8'hAA, AW_R = 8'hAB;

  i2c_eeprom_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .strap(3'b101), .tick_sel(tick_sel), .ext_tick(ext_tick), .sda_oe(sda_oe));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q; repeat (10) @(negedge clk); endtask
  task automatic start_c; m_sda = 1; q; m_scl = 1; q; m_sda = 0; q; m_scl = 0; q; endtask
  task automatic stop_c;  m_sda = 0; q; m_scl = 1; q; m_sda = 1; q; endtask
  task automatic wait_ready; repeat (600) @(negedge clk); endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q; m_scl = 1; q; q; m_scl = 0; q;
    end
    m_sda = 1; q; m_scl = 1; q; ack = ~sda_bus; q; m_scl = 0; q;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1; q; m_scl = 1; q; d[i] = sda_bus; q; m_scl = 0; q;
    end
    m_sda = ~mack; q; m_scl = 1; q; q; m_scl = 0; q; m_sda = 1;
  endtask

  task automatic wr(input logic [7:0] a, input int n, input string req);
    bit ack;
    start_c; wbyte(AW_W, ack); chk(ack, "R1", ack, 1);
    wbyte(a, ack); chk(ack, "R2", ack, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(dbuf[i], ack); chk(ack, req, ack, 1);
    end
    stop_c;
  endtask

  task automatic rd_body(input int n);
    for (int i = 0; i < n; i++) rbyte(i != n - 1, rbuf[i]);
    stop_c;
  endtask

  task automatic rd_rand(input logic [7:0] a, input int n);
    bit ack;
    start_c; wbyte(AW_W, ack); wbyte(a, ack);
    start_c; wbyte(AW_R, ack); chk(ack, "R8", ack, 1);
    rd_body(n);
  endtask

  task automatic t_reset;
    chk(sda_oe == 0, "R11", sda_oe, 0);
  endtask

  task automatic t_addr;
    bit ack;
    start_c; wbyte(AW_W, ack); chk(ack, "R11", ack, 1); stop_c;
    start_c; wbyte(8'hA2, ack); chk(!ack, "R1", ack, 0); stop_c;
    start_c; wbyte(8'hBA, ack); chk(!ack, "R1", ack, 0); stop_c;
  endtask

  task automatic t_byte_write;
    dbuf[0] = 8'h5C; wr(8'h10, 1, "R3"); wait_ready;
    rd_rand(8'h10, 1); chk(rbuf[0] == 8'h5C, "R3", rbuf[0], 8'h5C);
  endtask

  task automatic t_page;
    bit ack;
    logic [7:0] exp [9];
    for (int i = 0; i < 9; i++) dbuf[i] = 8'hC0 + 8'(i);
    wr(8'h23, 9, "R4"); wait_ready;
    start_c; wbyte(AW_R, ack); chk(ack, "R7", ack, 1); rd_body(1);
    chk(rbuf[0] == 8'hC1, "R7", rbuf[0], 8'hC1);
    exp = '{8'hC5, 8'hC6, 8'hC7, 8'hC8, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'h00};
    rd_rand(8'h20, 9);
    for (int i = 0; i < 9; i++) chk(rbuf[i] == exp[i], "R4", rbuf[i], exp[i]);
  endtask

  task automatic t_wrap;
    dbuf[0] = 8'h77; wr(8'hFF, 1, "R9"); wait_ready;
    dbuf[0] = 8'h11; wr(8'h00, 1, "R9"); wait_ready;
    rd_rand(8'hFE, 3);
    chk(rbuf[0] == 8'h00, "R9", rbuf[0], 8'h00);
    chk(rbuf[1] == 8'h77, "R9", rbuf[1], 8'h77);
    chk(rbuf[2] == 8'h11, "R9", rbuf[2], 8'h11);
  endtask

  task automatic t_busy;
    bit ack;
    dbuf[0] = 8'h99; wr(8'h40, 1, "R5");
    start_c; wbyte(AW_W, ack); chk(!ack, "R5", ack, 0); stop_c;
    wait_ready;
    start_c; wbyte(AW_W, ack); chk(ack, "R5", ack, 1); stop_c;
  endtask

  task automatic t_ext;
    bit ack;
    tick_sel = 1;
    dbuf[0] = 8'h42; wr(8'h41, 1, "R6");
    repeat (1000) @(negedge clk);
    start_c; wbyte(AW_W, ack); chk(!ack, "R6", ack, 0); stop_c;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk) ext_tick = 1; @(negedge clk) ext_tick = 0;
    end
    start_c; wbyte(AW_W, ack); chk(ack, "R6", ack, 1); stop_c;
    tick_sel = 0;
    rd_rand(8'h41, 1); chk(rbuf[0] == 8'h42, "R6", rbuf[0], 8'h42);
  endtask

  task automatic t_release;
    int bad = 0;
    rd_rand(8'h40, 2);
    chk(rbuf[0] == 8'h99, "R8", rbuf[0], 8'h99);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); if (sda_oe || !sda_bus) bad++;
    end
    chk(bad == 0, "R10", bad, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_addr;
    t_byte_write;
    t_page;
    t_wrap;
    t_busy;
    t_ext;
    t_release;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule